// File: doc/BRIEF.md
# Single-Cycle RISC Main Control Decoder

This block is the purely combinational control unit of a single-cycle, fixed-format, 32-bit load/store processor. From the 6-bit major opcode and the 6-bit function field of the current instruction, plus a flag that says whether the first source register reads as zero, it produces every steering and enable signal the datapath needs in that same cycle. Those signals cover the register-file write, the choice of destination register, how the 16-bit immediate is widened, the ALU operation, the ALU second operand, the data-memory write, the value written back and where the next PC comes from.

Supported instructions: register-register ALU operations (opcode 0), immediate arithmetic and logic, word load, word store, branch-if-zero, branch-if-nonzero, absolute jump, absolute jump with link, register jump and register jump with link. Any encoding outside that set is decoded to a harmless control word that writes nothing and steps to PC+4. The register file, ALU, memories and PC adders sit outside this block.

The control word is the same for an instruction no matter which other fields it carries, so the datapath can rely on each output being settled from opcode, function and zero flag alone.

Top module: `ctl_main_dec`

## Requirements
- R1: With opcode 0x00 and func 0x20/0x22/0x24/0x25/0x26/0x27/0x2A, reg_we=1, dst_sel=1 (rd), b_imm=0, mem_we=0, wb_src=0 (ALU), pc_src=0 (PC+4), and alu_op is 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 set-less-than respectively.
- R2: Opcodes 0x08 (add immediate) and 0x0A (set-less-than immediate) give reg_we=1, dst_sel=0 (rt), ext_zero=0 (sign extend), b_imm=1, wb_src=0, pc_src=0, alu_op 0 and 6.
- R3: Opcodes 0x0C, 0x0D, 0x0E (and/or/xor immediate) give reg_we=1, dst_sel=0, ext_zero=1 (zero extend), b_imm=1, wb_src=0, pc_src=0, alu_op 2, 3, 4.
- R4: Opcode 0x23 (load word) gives reg_we=1, dst_sel=0, ext_zero=0, alu_op=0, b_imm=1, mem_we=0, wb_src=1 (memory), pc_src=0.
- R5: Opcode 0x2B (store word) gives mem_we=1, reg_we=0, ext_zero=0, alu_op=0, b_imm=1, pc_src=0.
- R6: Opcode 0x04 (branch if zero) writes nothing and gives pc_src=1 (relative target) when rs_zero=1, pc_src=0 otherwise.
- R7: Opcode 0x05 (branch if nonzero) writes nothing and gives pc_src=1 when rs_zero=0, pc_src=0 otherwise.
- R8: Opcode 0x02 gives pc_src=3 (absolute target) with no writes; opcode 0x03 also gives reg_we=1, dst_sel=2 (register 31) and wb_src=2 (PC+4).
- R9: Opcode 0x00 with func 0x08 gives pc_src=2 (register target) with no writes; func 0x09 also gives reg_we=1, dst_sel=2, wb_src=2.
- R10: An unlisted opcode, or opcode 0x00 with an unlisted func, gives the idle word: every output 0 (no writes, PC+4).
- R11: Any output not named for an instruction above is 0; func has no effect when opcode is nonzero, and rs_zero has no effect except on the two branch opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| func | input | 6 | Function field, instruction bits 5:0 |
| rs_zero | input | 1 | First source register value equals zero |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| ext_zero | output | 1 | Immediate widening: 0 sign, 1 zero |
| alu_op | output | 4 | ALU operation code |
| b_imm | output | 1 | ALU second operand: 0 register, 1 immediate |
| mem_we | output | 1 | Data memory write enable |
| wb_src | output | 2 | Write-back value: 0 ALU, 1 memory, 2 PC+4 |
| pc_src | output | 2 | Next PC: 0 PC+4, 1 relative, 2 register, 3 absolute |

## Verification
The bench aims at the encodings that share opcode 0: a decoder that misread func 0x08/0x09 would treat a register jump as an ALU operation and write a register, or lose the link write. It flips rs_zero under both branch opcodes, where a swapped polarity would branch on the wrong condition, and under non-branch opcodes, where a leaky branch term would redirect the PC. It feeds an ALU-looking func under immediate, load and branch opcodes to catch a function decode that is not gated by opcode, and checks the logical immediates for zero extension, which a shared arithmetic path would get wrong by sign-extending. Unknown opcodes and unknown funcs must fall to the idle word rather than firing a write enable.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 4;

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_e;
  typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_BR = 2'd1, PC_REG = 2'd2, PC_ABS = 2'd3} pc_e;
  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLT = 4'd6
  } alu_e;

  typedef enum logic [3:0] {
    CL_BAD, CL_RR, CL_ARITH_I, CL_LOGIC_I, CL_LOAD, CL_STORE,
    CL_BR_EQZ, CL_BR_NEZ, CL_JUMP, CL_JLINK
  } cls_e;

  typedef enum logic [1:0] {FK_BAD, FK_ALU, FK_JREG, FK_JREG_LINK} fkind_e;

  localparam logic [OP_W-1:0] OPC_RR    = 6'h00;
  localparam logic [OP_W-1:0] OPC_J     = 6'h02;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OPC_BEQZ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNEZ  = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;

  localparam logic [FN_W-1:0] FN_JR   = 6'h08;
  localparam logic [FN_W-1:0] FN_JALR = 6'h09;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

  typedef struct packed {
    logic  reg_we;
    dst_e  dst;
    logic  ext_zero;
    alu_e  alu;
    logic  b_imm;
    logic  mem_we;
    wb_e   wb;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{
    reg_we: 1'b0, dst: DST_RT, ext_zero: 1'b0, alu: ALU_ADD,
    b_imm: 1'b0, mem_we: 1'b0, wb: WB_ALU
  };
endpackage

// File: rtl/ctl_opdec.sv
module ctl_opdec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output cls_e            cls,
  output alu_e            imm_alu
);
  always_comb begin
    cls     = CL_BAD;
    imm_alu = ALU_ADD;
    case (opcode)
      OPC_RR:   cls = CL_RR;
      OPC_ADDI: cls = CL_ARITH_I;
      OPC_SLTI: begin cls = CL_ARITH_I; imm_alu = ALU_SLT; end
      OPC_ANDI: begin cls = CL_LOGIC_I; imm_alu = ALU_AND; end
      OPC_ORI:  begin cls = CL_LOGIC_I; imm_alu = ALU_OR;  end
      OPC_XORI: begin cls = CL_LOGIC_I; imm_alu = ALU_XOR; end
      OPC_LW:   cls = CL_LOAD;
      OPC_SW:   cls = CL_STORE;
      OPC_BEQZ: cls = CL_BR_EQZ;
      OPC_BNEZ: cls = CL_BR_NEZ;
      OPC_J:    cls = CL_JUMP;
      OPC_JAL:  cls = CL_JLINK;
      default:  cls = CL_BAD;
    endcase
  end
endmodule

// File: rtl/ctl_funcdec.sv
module ctl_funcdec
  import ctl_pkg::*;
(
  input  logic [FN_W-1:0] func,
  output fkind_e          kind,
  output alu_e            alu
);
  always_comb begin
    kind = FK_ALU;
    alu  = ALU_ADD;
    case (func)
      FN_ADD:  alu = ALU_ADD;
      FN_SUB:  alu = ALU_SUB;
      FN_AND:  alu = ALU_AND;
      FN_OR:   alu = ALU_OR;
      FN_XOR:  alu = ALU_XOR;
      FN_NOR:  alu = ALU_NOR;
      FN_SLT:  alu = ALU_SLT;
      FN_JR:   kind = FK_JREG;
      FN_JALR: kind = FK_JREG_LINK;
      default: kind = FK_BAD;
    endcase
  end
endmodule

// File: rtl/ctl_nextpc.sv
module ctl_nextpc
  import ctl_pkg::*;
(
  input  cls_e   cls,
  input  fkind_e kind,
  input  logic   rs_zero,
  output pc_e    pc_sel
);
  always_comb begin
    pc_sel = PC_SEQ;
    case (cls)
      CL_BR_EQZ: pc_sel = rs_zero  ? PC_BR : PC_SEQ;
      CL_BR_NEZ: pc_sel = !rs_zero ? PC_BR : PC_SEQ;
      CL_JUMP, CL_JLINK: pc_sel = PC_ABS;
      CL_RR: pc_sel = (kind == FK_JREG || kind == FK_JREG_LINK) ? PC_REG : PC_SEQ;
      default: pc_sel = PC_SEQ;
    endcase
  end
endmodule

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] func,
  input  logic       rs_zero,
  output logic       reg_we,
  output logic [1:0] dst_sel,
  output logic       ext_zero,
  output logic [3:0] alu_op,
  output logic       b_imm,
  output logic       mem_we,
  output logic [1:0] wb_src,
  output logic [1:0] pc_src
);
  cls_e   cls;
  alu_e   imm_alu;
  fkind_e kind;
  alu_e   fn_alu;
  pc_e    pc_sel;
  ctl_t   w;

  ctl_opdec   u_op (.opcode(opcode), .cls(cls), .imm_alu(imm_alu));
  ctl_funcdec u_fn (.func(func), .kind(kind), .alu(fn_alu));
  ctl_nextpc  u_pc (.cls(cls), .kind(kind), .rs_zero(rs_zero), .pc_sel(pc_sel));

  always_comb begin
    w = CTL_IDLE;
    case (cls)
      CL_RR: begin
        case (kind)
          FK_ALU: begin
            w.reg_we = 1'b1;
            w.dst    = DST_RD;
            w.alu    = fn_alu;
          end
          FK_JREG_LINK: begin
            w.reg_we = 1'b1;
            w.dst    = DST_LINK;
            w.wb     = WB_LINK;
          end
          default: w = CTL_IDLE;
        endcase
      end
      CL_ARITH_I, CL_LOGIC_I: begin
        w.reg_we   = 1'b1;
        w.b_imm    = 1'b1;
        w.alu      = imm_alu;
        w.ext_zero = (cls == CL_LOGIC_I);
      end
      CL_LOAD: begin
        w.reg_we = 1'b1;
        w.b_imm  = 1'b1;
        w.wb     = WB_MEM;
      end
      CL_STORE: begin
        w.mem_we = 1'b1;
        w.b_imm  = 1'b1;
      end
      CL_JLINK: begin
        w.reg_we = 1'b1;
        w.dst    = DST_LINK;
        w.wb     = WB_LINK;
      end
      default: w = CTL_IDLE;
    endcase
  end

  assign reg_we   = w.reg_we;
  assign dst_sel  = w.dst;
  assign ext_zero = w.ext_zero;
  assign alu_op   = w.alu;
  assign b_imm    = w.b_imm;
  assign mem_we   = w.mem_we;
  assign wb_src   = w.wb;
  assign pc_src   = pc_sel;

  // Cross-checks between the control word and the separately decoded next-PC path.
  always_comb begin
    if (mem_we) begin
      assert_store_no_regwrite_R5: assert (!reg_we && b_imm);
    end
    if (pc_src == PC_BR) begin
      assert_branch_no_write_R6: assert (!reg_we && !mem_we && (opcode == OPC_BEQZ || opcode == OPC_BNEZ));
    end
    assert_link_pairing_R8: assert ((wb_src == WB_LINK) == (dst_sel == DST_LINK));
    if (wb_src == WB_LINK) begin
      assert_link_jumps_R9: assert (pc_src == PC_ABS || pc_src == PC_REG);
    end
    if (ext_zero) begin
      assert_zero_ext_imm_R3: assert (b_imm && reg_we);
    end
    if (pc_src == PC_REG) begin
      assert_regjump_rr_only_R9: assert (opcode == OPC_RR);
    end
    if (cls == CL_BAD) begin
      assert_unknown_safe_R10: assert (!reg_we && !mem_we && pc_src == PC_SEQ);
    end
  end
endmodule

// File: tb/ctl_main_dec_test.sv
module ctl_main_dec_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0] opcode, func;
  logic       rs_zero;
  logic       reg_we, ext_zero, b_imm, mem_we;
  logic [1:0] dst_sel, wb_src, pc_src;
  logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ctl_main_dec uut (
    .opcode(opcode), .func(func), .rs_zero(rs_zero),
    .reg_we(reg_we), .dst_sel(dst_sel), .ext_zero(ext_zero), .alu_op(alu_op),
    .b_imm(b_imm), .mem_we(mem_we), .wb_src(wb_src), .pc_src(pc_src)
  );

  // {req, opcode, func, rs_zero, we, dst, ext, alu, bimm, mwe, wb, pc}
  localparam logic [30:0] VEC [0:NVEC-1] = '{
    {4'd1, 6'h00, 6'h20, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 add
    {4'd1, 6'h00, 6'h22, 1'b1, 1'b1, 2'd1, 1'b0, 4'd1, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 sub
    {4'd1, 6'h00, 6'h24, 1'b0, 1'b1, 2'd1, 1'b0, 4'd2, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 and
    {4'd1, 6'h00, 6'h25, 1'b0, 1'b1, 2'd1, 1'b0, 4'd3, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 or
    {4'd1, 6'h00, 6'h26, 1'b0, 1'b1, 2'd1, 1'b0, 4'd4, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 xor
    {4'd1, 6'h00, 6'h27, 1'b1, 1'b1, 2'd1, 1'b0, 4'd5, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 nor
    {4'd1, 6'h00, 6'h2A, 1'b0, 1'b1, 2'd1, 1'b0, 4'd6, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 slt
    {4'd2, 6'h08, 6'h00, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 2'd0, 2'd0}, // R2 addi
    {4'd2, 6'h0A, 6'h00, 1'b0, 1'b1, 2'd0, 1'b0, 4'd6, 1'b1, 1'b0, 2'd0, 2'd0}, // R2 slti
    {4'd3, 6'h0C, 6'h00, 1'b0, 1'b1, 2'd0, 1'b1, 4'd2, 1'b1, 1'b0, 2'd0, 2'd0}, // R3 andi
    {4'd3, 6'h0D, 6'h00, 1'b0, 1'b1, 2'd0, 1'b1, 4'd3, 1'b1, 1'b0, 2'd0, 2'd0}, // R3 ori
    {4'd3, 6'h0E, 6'h00, 1'b0, 1'b1, 2'd0, 1'b1, 4'd4, 1'b1, 1'b0, 2'd0, 2'd0}, // R3 xori
    {4'd4, 6'h23, 6'h00, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 2'd1, 2'd0}, // R4 load
    {4'd5, 6'h2B, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 1'b1, 2'd0, 2'd0}, // R5 store
    {4'd6, 6'h04, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1}, // R6 taken
    {4'd6, 6'h04, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R6 not taken
    {4'd7, 6'h05, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1}, // R7 taken
    {4'd7, 6'h05, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R7 not taken
    {4'd8, 6'h02, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd3}, // R8 jump
    {4'd8, 6'h03, 6'h00, 1'b0, 1'b1, 2'd2, 1'b0, 4'd0, 1'b0, 1'b0, 2'd2, 2'd3}, // R8 jump link
    {4'd9, 6'h00, 6'h08, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd2}, // R9 reg jump
    {4'd9, 6'h00, 6'h09, 1'b1, 1'b1, 2'd2, 1'b0, 4'd0, 1'b0, 1'b0, 2'd2, 2'd2}, // R9 reg jump link
    {4'd10, 6'h3F, 6'h20, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R10 bad opcode
    {4'd10, 6'h00, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R10 bad func 0
    {4'd10, 6'h00, 6'h21, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R10 bad func
    {4'd10, 6'h01, 6'h08, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0}  // R10 bad opcode
  };

  function automatic logic [13:0] observed();
    return {reg_we, dst_sel, ext_zero, alu_op, b_imm, mem_we, wb_src, pc_src};
  endfunction

  task automatic apply_check(input int req, input logic [5:0] op, input logic [5:0] fn,
                             input logic z, input logic [13:0] exp);
    @(posedge clk);
    opcode = op; func = fn; rs_zero = z;
    @(negedge clk);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL R%0d op=%h fn=%h z=%b: got %b expected %b", req, op, fn, z, observed(), exp);
    end
  endtask

  initial begin
    opcode = 6'h00; func = 6'h00; rs_zero = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R10: power-up input pattern (all-zero instruction) must decode to the idle word
    @(negedge clk);
    checks++;
    if (observed() !== 14'd0) begin
      errors++;
      $display("FAIL R10 idle at start: got %b expected %b", observed(), 14'd0);
    end
    for (int i = 0; i < NVEC; i++) begin
      apply_check(int'(VEC[i][30:27]), VEC[i][26:21], VEC[i][20:15], VEC[i][14], VEC[i][13:0]);
    end
    // R11: func and rs_zero ignored outside their own instructions
    apply_check(11, 6'h08, 6'h09, 1'b1, {1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 2'd0, 2'd0});
    apply_check(11, 6'h23, 6'h08, 1'b1, {1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 2'd1, 2'd0});
    apply_check(11, 6'h02, 6'h09, 1'b1, {1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd3});
    apply_check(11, 6'h2B, 6'h2A, 1'b1, {1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 1'b1, 2'd0, 2'd0});
    apply_check(11, 6'h0D, 6'h22, 1'b1, {1'b1, 2'd0, 1'b1, 4'd3, 1'b1, 1'b0, 2'd0, 2'd0});
    apply_check(11, 6'h00, 6'h26, 1'b1, {1'b1, 2'd1, 1'b0, 4'd4, 1'b0, 1'b0, 2'd0, 2'd0});
    // R6/R7 with an ALU-looking func present
    apply_check(6, 6'h04, 6'h20, 1'b1, {1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd1});
    apply_check(7, 6'h05, 6'h09, 1'b1, 14'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule